// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (I2C signalling, SCL and SDA) and accepts write transfers only. It answers to one fixed address byte. Each transfer begins with two filler bytes, which the block acknowledges and throws away. The data bytes that follow fill a small bank of 8-bit control registers one after another, always starting at register 0. The registers drive the clock logic directly as a flat parallel bus.

There is no register pointer and the bank cannot be read back. To change a later register, the host must resend every register below it. A fast system clock oversamples both bus lines. START and STOP are found from line edges, and the open-drain pull-down on SDA is a single output-enable. An active-low power-down input silences the port and leaves the register contents as they are. Only the synchronous reset, which stands for true power-up, loads the default values.

Top module: `cfg_i2c_wr_slave`

## Requirements
- R1: After reset the bank holds the following default values. Register 0 is 0x0C, register 2 is 0x7F and register 3 is 0xFF. Every other register is 0x00. Register k sits at bits [8k+7:8k] of `ctrl_regs_o`.
- R2: Only the address byte 0xD2 is acknowledged, meaning a 7-bit address with a write bit of 0 in the LSB. Any other first byte, including the read form 0xD3, gets no acknowledge. Such a byte also leaves every register unchanged.
- R3: The two bytes after the address are acknowledged and discarded. They change no register.
- R4: Data bytes are shifted in MSB first. The first data byte lands in register 0, the next in register 1, and so on, one register per byte. Registers that are not reached keep their values.
- R5: At most 10 bytes after the address are acknowledged, which is the two filler bytes plus eight data bytes. Any later byte gets no acknowledge and changes nothing.
- R6: For an accepted byte, `sda_oe` rises while SCL is low after the eighth bit. It stays high through the ninth clock and drops after that clock falls. The port is idle after a STOP, and `sda_oe` stays low while it is idle.
- R7: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A repeated START aborts the current transfer and begins a new address phase. A STOP returns the port to idle.
- R8: A byte cut short by a STOP or a repeated START is discarded. Registers change only through completed, acknowledged data bytes.
- R9: While `pwr_dn_n` is low, the port sends no acknowledge and writes nothing. Register contents are preserved through power-down and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; loads the default register values |
| pwr_dn_n | input | 1 | Active-low power-down; disables the port and keeps the registers |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| ctrl_regs_o | output | NUM_REGS*8 | Control register bank; register k at bits [8k+7:8k] |

## Verification
The assertions check the following on every cycle. `sda_oe` is never driven during power-down and is released after any STOP. An acknowledge only begins while the synchronized SCL is low. The bank is frozen during power-down and changes only in the cycle after a single write strobe. The bench scenarios show the rest: which address bytes earn an acknowledge, how the filler bytes are dropped, the register order, the byte-count limit, and what happens to bytes cut short. The bench checks all of these at the ports against a register model it keeps itself.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_RECV,
    LNK_HOLD,
    LNK_ACK,
    LNK_SKIP
  } link_state_t;

  // Default (power-up) value of control register idx
  function automatic logic [7:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 8'h0C;
      2:       return 8'h7F;
      3:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], line_i};
  end

  assign level_o = sr[STAGES-1];
  assign rise_o  = sr[STAGES-1] & ~sr[STAGES];
  assign fall_o  = ~sr[STAGES-1] & sr[STAGES];
endmodule

// File: rtl/cfg_wr_fsm.sv
module cfg_wr_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE   = 8'hD2,
  parameter int         DUMMY_BYTES = 2,
  parameter int         MAX_BYTES   = 10,
  parameter int         NUM_REGS    = 8,
  parameter int         IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam int CNT_W = $clog2(MAX_BYTES + 2);

  link_state_t      state;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [6:0]       shreg;
  logic             ack_q;

  logic [7:0] full_byte;
  logic       accept;
  logic       is_data;
  int         data_off;

  assign full_byte = {shreg, sda_lvl};
  assign data_off  = int'(byte_cnt) - (DUMMY_BYTES + 1);

  always_comb begin
    if (byte_cnt == '0) accept = (full_byte == ADDR_BYTE);
    else                accept = (int'(byte_cnt) <= MAX_BYTES);
    is_data = (data_off >= 0) && (data_off < NUM_REGS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LNK_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      ack_q    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!enable) begin
        state  <= LNK_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state    <= LNK_RECV;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= LNK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          LNK_RECV: begin
            if (scl_rise) begin
              shreg   <= full_byte[6:0];
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                state <= LNK_HOLD;
                ack_q <= accept;
                if (accept && is_data) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IDX_W'(data_off);
                  wr_data <= full_byte;
                end
              end
            end
          end
          LNK_HOLD: begin
            if (scl_fall) begin
              if (ack_q) begin
                sda_oe <= 1'b1;
                state  <= LNK_ACK;
              end else begin
                state <= LNK_SKIP;
              end
            end
          end
          LNK_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              bit_cnt  <= '0;
              byte_cnt <= byte_cnt + 1'b1;
              state    <= LNK_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= reg_reset_value(g);
      else if (wr_en && enable && wr_idx == IDX_W'(g))
        q <= wr_data;
    end
    assign regs_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/cfg_i2c_wr_slave.sv
module cfg_i2c_wr_slave #(
  parameter logic [7:0] ADDR_BYTE   = 8'hD2,
  parameter int         DUMMY_BYTES = 2,
  parameter int         MAX_BYTES   = 10,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_dn_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] ctrl_regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfg_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  cfg_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  cfg_wr_fsm #(
    .ADDR_BYTE(ADDR_BYTE), .DUMMY_BYTES(DUMMY_BYTES), .MAX_BYTES(MAX_BYTES),
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .enable(pwr_dn_n),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .enable(pwr_dn_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_o(ctrl_regs_o)
  );
endmodule

// File: rtl/cfg_i2c_wr_slave_chk.sv
module cfg_i2c_wr_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pwr_dn_n,
  input logic                  sda_oe,
  input logic                  scl_lvl,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] ctrl_regs
);
  assert_quiet_in_powerdown_R9: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn_n |=> !sda_oe);

  assert_regs_held_in_powerdown_R9: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn_n |=> $stable(ctrl_regs));

  assert_ack_starts_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  assert_stop_releases_sda_R7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_single_write_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_regs_change_only_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(ctrl_regs));
endmodule

bind cfg_i2c_wr_slave cfg_i2c_wr_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .sda_oe(sda_oe),
  .scl_lvl(scl_lvl), .stop_det(stop_det), .wr_en(wr_en),
  .ctrl_regs(ctrl_regs_o)
);

// File: tb/test_cfg_i2c_wr_slave.sv
module test_cfg_i2c_wr_slave;
  localparam int NREG = 8;
  localparam int Q    = 6;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn_n = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_regs [NREG];
  bit last_oe;

  assign sda_line = sda_m & ~sda_oe;

  cfg_i2c_wr_slave #(.NUM_REGS(NREG)) i_cfg_i2c_wr_slave (
    .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe), .ctrl_regs_o(regs)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(regs[i*8 +: 8] == exp_regs[i], req, 64'(regs[i*8 +: 8]), 64'(exp_regs[i]));
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    exp_regs[0] = 8'h0C;
    exp_regs[2] = 8'h7F;
    exp_regs[3] = 8'hFF;
  endtask

  task automatic bus_start();
    scl = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    acked   = (sda_line == 1'b0);
    last_oe = sda_oe;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_header(input string req);
    bit a;
    send_byte(8'hD2, a); check(a, "R2", 64'(a), 64'd1);
    send_byte(8'hA5, a); check(a, req, 64'(a), 64'd1);
    send_byte(8'h3C, a); check(a, req, 64'(a), 64'd1);
  endtask

  initial begin
    bit a;
    logic [7:0] pat;
    load_defaults();
    tick(4);
    rst = 1'b0;
    tick(4);

    // R1 defaults, R6 idle
    check_regs("R1");
    check(sda_oe == 1'b0, "R6", 64'(sda_oe), 64'd0);

    // R2: sweep every possible address byte
    for (int ad = 0; ad < 256; ad++) begin
      bus_start();
      send_byte(8'(ad), a);
      bus_stop();
      check(a == (ad == 8'hD2), "R2", 64'(a), 64'(ad == 8'hD2));
    end
    check_regs("R2");

    // R3, R4, R5: full transfer plus one extra byte
    bus_start();
    send_header("R3");
    check(last_oe == 1'b1, "R6", 64'(last_oe), 64'd1);
    check_regs("R3");
    for (int i = 0; i < NREG; i++) begin
      pat = 8'((i + 1) * 8'h1D) ^ 8'h80;
      send_byte(pat, a);
      exp_regs[i] = pat;
      check(a, "R4", 64'(a), 64'd1);
      check(regs[i*8 +: 8] == pat, "R4", 64'(regs[i*8 +: 8]), 64'(pat));
    end
    send_byte(8'h55, a);
    check(!a, "R5", 64'(a), 64'd0);
    bus_stop();
    tick(2);
    check(sda_oe == 1'b0, "R6", 64'(sda_oe), 64'd0);
    check_regs("R5");

    // R4: MSB first, short transfer leaves upper registers alone
    bus_start();
    send_header("R3");
    send_byte(8'h01, a); exp_regs[0] = 8'h01;
    send_byte(8'hE0, a); exp_regs[1] = 8'hE0;
    bus_stop();
    check_regs("R4");

    // R8: byte cut short by STOP is dropped
    bus_start();
    send_header("R3");
    send_byte(8'hAA, a); exp_regs[0] = 8'hAA;
    send_bits(8'h0F, 4);
    bus_stop();
    check_regs("R8");

    // R7/R8: repeated START mid-byte, then repeated START between bytes
    bus_start();
    send_header("R3");
    send_byte(8'h11, a); exp_regs[0] = 8'h11;
    send_bits(8'h3C, 5);
    bus_start();
    send_header("R7");
    send_byte(8'h22, a); exp_regs[0] = 8'h22;
    bus_start();
    send_byte(8'hD2, a);
    check(a, "R7", 64'(a), 64'd1);
    bus_stop();
    check_regs("R7");

    // R9: power-down silences the port and keeps the bank
    pwr_dn_n = 1'b0;
    tick(4);
    bus_start();
    send_byte(8'hD2, a);
    check(!a, "R9", 64'(a), 64'd0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h99, a);
    check(!a, "R9", 64'(a), 64'd0);
    bus_stop();
    check_regs("R9");
    pwr_dn_n = 1'b1;
    tick(4);
    check_regs("R9");
    bus_start();
    send_byte(8'hD2, a);
    check(a, "R9", 64'(a), 64'd1);
    bus_stop();

    // R1: reset restores defaults
    rst = 1'b1; tick(3); rst = 1'b0; tick(3);
    load_defaults();
    check_regs("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule